// File: doc/BRIEF.md
# Two-Stage Expansion ROM Bank Selector

This block sits on the expansion side of a small 8-bit computer bus. It watches CPU write cycles aimed at the machine's ROM paging register and keeps a copy of which of the sixteen logical ROM slots is currently selected. Twelve of those slots live on the expansion hardware, and the block drives their chip enables. The other four slots, the keyboard pair 8–9 and the interpreter pair 10–11, are inside the host machine. The block does not drive them. It only reports whether the host's own ROMs have been paged out.

Software reaches the external slots in two ways. The upper group, slots 12 to 15, is selected by one write whose low nibble has bits 3:2 set. That write also pages the internal ROMs out. The lower group, slots 0 to 7, is selected by a write with bit 3 clear. Such a write only counts once an upper-group write has already paged the internal ROMs out. For that reason the selection is held in a small state machine rather than a plain latch. The address decode for the ROM window is reduced to one enable input, `rom_window`, which gates the chip enables.

Top module: `bank_page_selector`

## Requirements
- R1: After reset, `slot_valid` and `internal_paged_out` are 0, `active_slot` is 0 and every bit of `slot_en` is 0.
- R2: A write cycle (`cpu_rnw`=0) to the paging address whose data bits 3:2 are 11 makes, from the next clock, `active_slot` = 12 + data[1:0], with `slot_valid`=1 and `internal_paged_out`=1.
- R3: While `internal_paged_out` is 1, a paging write with data bit 3 = 0 makes, from the next clock, `active_slot` = data[2:0] and `slot_valid`=1, and `internal_paged_out` stays 1. This also holds after an earlier lower-group selection.
- R4: While `internal_paged_out` is 0, a paging write with data bit 3 = 0 is ignored, and `active_slot`, `slot_valid` and `internal_paged_out` keep their values.
- R5: A paging write with data bits 3:2 = 10 returns control to the internal ROMs. From the next clock, `internal_paged_out`=0, `slot_valid`=0, `active_slot` = data[3:0] (8 to 11), and all of `slot_en` is 0.
- R6: Data bits 7:4 of a paging write do not affect the result (default configuration).
- R7: Read cycles to the paging address, and write cycles to any other address, leave all outputs unchanged.
- R8: `slot_en` bit k (k = 0..7) enables slot k, and bit 8+j (j = 0..3) enables slot 12+j. At most one bit is set. A bit is set only while `slot_valid`=1, `rom_window`=1, and it is the bit of `active_slot`.
- R9: `slot_valid` is never 1 while `internal_paged_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU bus clock; writes are sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data | input | 8 | CPU data bus |
| cpu_rnw | input | 1 | 1 = read cycle, 0 = write cycle |
| rom_window | input | 1 | High while the CPU addresses the paged ROM window |
| active_slot | output | 4 | Number of the selected logical slot |
| slot_valid | output | 1 | An external slot is selected |
| slot_en | output | 12 | Chip enables: bits 0–7 for slots 0–7, bits 8–11 for slots 12–15 |
| internal_paged_out | output | 1 | The host's keyboard and interpreter ROMs are paged out |

## Verification
The assertions check some behaviours on every cycle. The enables never have more than one bit set and are dark outside the ROM window. A valid external selection always implies that the internal ROMs are out. The state holds whenever no paging write occurs. An upper-group write always lands in 12–15, a write to the internal group always clears the selection, and a lower-group write while the internal ROMs are in changes nothing. Other behaviours only the directed scenarios can show. These are the exact slot number each data value maps to, the bit position each slot drives in `slot_en`, the two-write sequence needed to reach the lower banks, and the fact that stray reads, neighbouring addresses and upper data bits have no effect.

// File: rtl/bank_sel_pkg.sv
package bank_sel_pkg;

   // Logical slot space and its split between host and expansion.
   localparam int SLOT_W     = 4;
   localparam int N_SLOTS    = 1 << SLOT_W;
   localparam int LOW_BANKS  = 8;
   localparam int INT_SLOTS  = 4;
   localparam int EXT_SLOTS  = N_SLOTS - INT_SLOTS;
   localparam int CODE_W     = 4;

   // Decoded meaning of one paging write.
   typedef enum logic [1:0] {
      REQ_NONE     = 2'd0,
      REQ_HIGH     = 2'd1,
      REQ_LOW      = 2'd2,
      REQ_INTERNAL = 2'd3
   } page_req_t;

   typedef struct packed {
      logic [SLOT_W-1:0] slot;
      logic              valid;
      logic              paged_out;
   } sel_state_t;

   // Classify a low nibble written to the paging register.
   function automatic page_req_t classify(input logic [CODE_W-1:0] code);
      if (code[3:2] == 2'b11)      return REQ_HIGH;
      else if (code[3] == 1'b0)    return REQ_LOW;
      else                         return REQ_INTERNAL;
   endfunction

endpackage

// File: rtl/bank_write_snoop.sv
module bank_write_snoop
   import bank_sel_pkg::*;
#(
   parameter int          ADDR_W       = 16,
   parameter int          DATA_W       = 8,
   parameter logic [ADDR_W-1:0] PAGE_ADDR = 16'hFE05,
   parameter bit          IGNORE_UPPER = 1'b1
) (
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_data,
   input  logic              cpu_rnw,
   output logic              wr_hit,
   output logic [CODE_W-1:0] wr_code
);

   logic addr_match;
   logic upper_ok;

   assign addr_match = (cpu_addr == PAGE_ADDR);
   // Strict variant drops writes whose upper bits are not zero.
   assign upper_ok   = IGNORE_UPPER || (cpu_data[DATA_W-1:CODE_W] == '0);
   assign wr_hit     = addr_match && !cpu_rnw && upper_ok;
   assign wr_code    = cpu_data[CODE_W-1:0];

endmodule

// File: rtl/bank_select_fsm.sv
module bank_select_fsm
   import bank_sel_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_hit,
   input  logic [CODE_W-1:0] wr_code,
   output sel_state_t        state
);

   page_req_t  req;
   sel_state_t nxt;

   assign req = wr_hit ? classify(wr_code) : REQ_NONE;

   always_comb begin
      nxt = state;
      unique case (req)
         REQ_HIGH: begin
            nxt.slot      = {2'b11, wr_code[1:0]};
            nxt.valid     = 1'b1;
            nxt.paged_out = 1'b1;
         end
         REQ_LOW: begin
            // Lower banks only reachable once the host ROMs are out.
            if (state.paged_out) begin
               nxt.slot  = {1'b0, wr_code[2:0]};
               nxt.valid = 1'b1;
            end
         end
         REQ_INTERNAL: begin
            nxt.slot      = wr_code;
            nxt.valid     = 1'b0;
            nxt.paged_out = 1'b0;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= '0;
      else        state <= nxt;
   end

   // Hold when no paging write is seen (R7).
   p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_hit |=> $stable(state));

   // Lower-group write ignored while host ROMs are paged in (R4).
   p_low_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && !wr_code[3] && !state.paged_out) |=> $stable(state));

   // Upper-group write lands in 12..15 with host ROMs out (R2).
   p_high_select_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && wr_code[3:2] == 2'b11) |=>
         (state.valid && state.paged_out && state.slot[3:2] == 2'b11));

   // Internal-group write hands control back (R5).
   p_internal_back_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && wr_code[3:2] == 2'b10) |=> (!state.valid && !state.paged_out));

   // Valid selection only with host ROMs out (R9).
   p_valid_needs_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
      state.valid |-> state.paged_out);

endmodule

// File: rtl/bank_enable_decode.sv
module bank_enable_decode
   import bank_sel_pkg::*;
(
   input  logic [SLOT_W-1:0]    slot,
   input  logic                 valid,
   input  logic                 rom_window,
   output logic [EXT_SLOTS-1:0] slot_en
);

   for (genvar i = 0; i < EXT_SLOTS; i++) begin : g_en
      // Enable bits skip over the host's internal slot range.
      localparam int SLOT_NUM = (i < LOW_BANKS) ? i : i + INT_SLOTS;
      assign slot_en[i] = valid && rom_window &&
                          (slot == SLOT_W'(SLOT_NUM));
   end

   // At most one enable (R8).
   always_comb begin
      a_en_onehot_r8: assert ($onehot0(slot_en) || $isunknown(slot_en));
   end

endmodule

// File: rtl/bank_page_selector.sv
module bank_page_selector
   import bank_sel_pkg::*;
#(
   parameter int          ADDR_W       = 16,
   parameter int          DATA_W       = 8,
   parameter logic [ADDR_W-1:0] PAGE_ADDR = 16'hFE05,
   parameter bit          IGNORE_UPPER = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    cpu_addr,
   input  logic [DATA_W-1:0]    cpu_data,
   input  logic                 cpu_rnw,
   input  logic                 rom_window,
   output logic [SLOT_W-1:0]    active_slot,
   output logic                 slot_valid,
   output logic [EXT_SLOTS-1:0] slot_en,
   output logic                 internal_paged_out
);

   if (DATA_W < 8) begin : g_bad_data
      $error("bank_page_selector: DATA_W must be at least 8");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("bank_page_selector: ADDR_W must be positive");
   end

   logic              wr_hit;
   logic [CODE_W-1:0] wr_code;
   sel_state_t        state;

   bank_write_snoop #(
      .ADDR_W       (ADDR_W),
      .DATA_W       (DATA_W),
      .PAGE_ADDR    (PAGE_ADDR),
      .IGNORE_UPPER (IGNORE_UPPER)
   ) u_snoop (
      .cpu_addr (cpu_addr),
      .cpu_data (cpu_data),
      .cpu_rnw  (cpu_rnw),
      .wr_hit   (wr_hit),
      .wr_code  (wr_code)
   );

   bank_select_fsm u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_hit  (wr_hit),
      .wr_code (wr_code),
      .state   (state)
   );

   bank_enable_decode u_dec (
      .slot       (state.slot),
      .valid      (state.valid),
      .rom_window (rom_window),
      .slot_en    (slot_en)
   );

   assign active_slot        = state.slot;
   assign slot_valid         = state.valid;
   assign internal_paged_out = state.paged_out;

   // Enables dark outside the ROM window (R8).
   p_en_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !rom_window |-> (slot_en == '0));

   // Enables dark while the host ROMs own the window (R5).
   p_en_internal_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !internal_paged_out |-> (slot_en == '0));

endmodule

// File: tb/tb_bank_page_selector.sv
module tb_bank_page_selector;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = 16'h0000;
   logic [7:0]  cpu_data = 8'h00;
   logic        cpu_rnw = 1'b1;
   logic        rom_window = 1'b1;
   logic [3:0]  active_slot;
   logic        slot_valid;
   logic [11:0] slot_en;
   logic        internal_paged_out;

   int checks = 0;
   int errors = 0;

   // Reference state built from the requirements.
   logic [3:0] m_slot = 4'd0;
   logic       m_valid = 1'b0;
   logic       m_out = 1'b0;

   always #4 clk = ~clk;

   bank_page_selector dut (
      .clk                (clk),
      .rst_n              (rst_n),
      .cpu_addr           (cpu_addr),
      .cpu_data           (cpu_data),
      .cpu_rnw            (cpu_rnw),
      .rom_window         (rom_window),
      .active_slot        (active_slot),
      .slot_valid         (slot_valid),
      .slot_en            (slot_en),
      .internal_paged_out (internal_paged_out)
   );

   function automatic logic [11:0] exp_en();
      logic [11:0] e = '0;
      if (m_valid && rom_window)
         e[(m_slot < 4'd8) ? int'(m_slot) : int'(m_slot) - 4] = 1'b1;
      return e;
   endfunction

   task automatic check(input string req);
      logic [18:0] act, exp;
      act = {active_slot, slot_valid, internal_paged_out, slot_en, 1'b0};
      exp = {m_slot, m_valid, m_out, exp_en(), 1'b0};
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: slot=%0d valid=%b out=%b en=%h, expected slot=%0d valid=%b out=%b en=%h",
                  req, active_slot, slot_valid, internal_paged_out, slot_en,
                  m_slot, m_valid, m_out, exp_en());
      end
   endtask

   // One bus cycle, driven after a falling edge; model updated from requirements.
   task automatic bus_cycle(input logic [15:0] a, input logic [7:0] d, input logic rnw);
      @(negedge clk);
      cpu_addr = a; cpu_data = d; cpu_rnw = rnw;
      @(negedge clk);
      cpu_rnw = 1'b1; cpu_addr = 16'h8000;
      if (a == 16'hFE05 && !rnw) begin
         if (d[3:2] == 2'b11) begin
            m_slot = {2'b11, d[1:0]}; m_valid = 1'b1; m_out = 1'b1;
         end else if (!d[3]) begin
            if (m_out) begin m_slot = {1'b0, d[2:0]}; m_valid = 1'b1; end
         end else begin
            m_slot = d[3:0]; m_valid = 1'b0; m_out = 1'b0;
         end
      end
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      m_slot = 4'd0; m_valid = 1'b0; m_out = 1'b0;
      repeat (3) @(negedge clk);
      check("R1 in reset");
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset");
   endtask

   task automatic t_high_select;
      for (int b = 0; b < 4; b++) begin
         bus_cycle(16'hFE05, 8'(8'h0C + b), 1'b0);
         check("R2 high bank select / R8 enable position");
      end
   endtask

   task automatic t_low_blocked;
      bus_cycle(16'hFE05, 8'h03, 1'b0);
      check("R4 low write with host ROMs in");
      bus_cycle(16'hFE05, 8'h0A, 1'b0);
      bus_cycle(16'hFE05, 8'h05, 1'b0);
      check("R4 low write after return to host");
   endtask

   task automatic t_low_select;
      for (int b = 0; b < 8; b++) begin
         bus_cycle(16'hFE05, 8'h0C, 1'b0);
         bus_cycle(16'hFE05, 8'(b), 1'b0);
         check("R3 low bank after high select / R8");
      end
      bus_cycle(16'hFE05, 8'h06, 1'b0);
      check("R3 low bank after low bank");
   endtask

   task automatic t_internal_return;
      bus_cycle(16'hFE05, 8'h0F, 1'b0);
      bus_cycle(16'hFE05, 8'h09, 1'b0);
      check("R5 return to keyboard slot");
      bus_cycle(16'hFE05, 8'h0D, 1'b0);
      bus_cycle(16'hFE05, 8'h0B, 1'b0);
      check("R5 return to interpreter slot");
   endtask

   task automatic t_upper_nibble;
      bus_cycle(16'hFE05, 8'hFD, 1'b0);
      check("R6 upper bits set, high select");
      bus_cycle(16'hFE05, 8'hA2, 1'b0);
      check("R6 upper bits set, low select");
   endtask

   task automatic t_ignored_cycles;
      bus_cycle(16'hFE05, 8'h0E, 1'b1);
      check("R7 read of paging address");
      bus_cycle(16'hFE04, 8'h0E, 1'b0);
      check("R7 write to neighbour below");
      bus_cycle(16'hFE15, 8'h0A, 1'b0);
      check("R7 write to aliasing address");
      bus_cycle(16'h7E05, 8'h0F, 1'b0);
      check("R7 write with top address bit clear");
   endtask

   task automatic t_window_gate;
      bus_cycle(16'hFE05, 8'h0E, 1'b0);
      rom_window = 1'b0;
      #1;
      check("R8 enables gated off outside window");
      rom_window = 1'b1;
      #1;
      check("R8 enables back inside window");
   endtask

   task automatic t_reset_midrun;
      bus_cycle(16'hFE05, 8'h0C, 1'b0);
      bus_cycle(16'hFE05, 8'h04, 1'b0);
      t_reset();
      bus_cycle(16'hFE05, 8'h02, 1'b0);
      check("R4 low write blocked after reset (R9 valid stays low)");
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      t_reset();
      t_low_blocked();
      t_high_select();
      t_low_select();
      t_internal_return();
      t_upper_nibble();
      t_ignored_cycles();
      t_window_gate();
      t_reset_midrun();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule